// File: doc/BRIEF.md
# Approximate Truncating Systolic Multiply-Accumulate Grid

This block is a rectangular grid of multiply-accumulate cells that computes the product of two matrices for neural network inference. Each cell owns one output element. Activation values enter the grid on the left edge, one lane per row. Weight values enter on the top edge, one lane per column. Every cell keeps the pair it received for one cycle and then passes the activation to the cell on its right and the weight to the cell below it. An operand of row i must therefore be launched i cycles after the matching operand of row 0, and an operand of column j must be launched j cycles after the matching operand of column 0.

To save area, a cell does not multiply its full operands. It keeps only the upper slice of each one, multiplies the two slices in a small multiplier, and shifts the product left to restore its scale. The shifted product then enters an accumulator whose adder has no carry chain across its low bits. All values are unsigned. A synchronous clear and a global enable control the accumulation, and every accumulator can be read in parallel at all times.

Top module: `amac_grid`

## Requirements
- R1: While reset is low, and on the first sample after it is released, every accumulator reads zero.
- R2: `clr` high at a clock edge zeroes every accumulator, whatever the data and whatever the state of `en`.
- R3: While `en` is low (and `clr` is low), the accumulators do not change, and the operand registers between cells keep their contents. An activation that is presented while `en` is low never reaches the next column.
- R4: Each operand is cut to its top `MUL_W` bits, counted down from the operand's own most significant bit. Lower bits are ignored. With the default widths (8-bit operands, `MUL_W` = 6), an activation of 0x03 contributes nothing, and 0x07 acts as 0x04.
- R5: The product of the two slices is shifted left by the total number of dropped bits (4 with the defaults). For example, 0xF0 × 0xF0 adds 0xE100 to a cleared accumulator.
- R6: The accumulator update works as follows. The low `OR_BITS` bits (6 by default) are the bitwise OR of the old value and the product, with no carry out of them. The upper bits are the exact sum of the two upper parts, plus a carry-in equal to the AND of the two bits at position `OR_BITS`-1. The result wraps at `ACC_W` bits. Adding the product 0x3F0 twice from zero gives 0x7F0.
- R7: The activation at a cell reaches the next cell to the right one enabled cycle later. The weight reaches the next cell below one enabled cycle later.
- R8: When the left inputs are skewed by row, the top inputs are skewed by column, and all lanes are zero outside the data, cell (i,j) ends with the approximate sum of its products. This sum is taken over k in increasing order, with A[i][k] from the activation side and B[k][j] from the weight side.
- R9: A zero operand on either side leaves that cell's accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear of all accumulators |
| en | input | 1 | Accumulate and advance the operand registers |
| feat_in | input | ROWS*DW | Activation for each row; row r is at bits [r*DW +: DW] |
| wgt_in | input | COLS*WW | Weight for each column; column c is at bits [c*WW +: WW] |
| acc_out | output | ROWS*COLS*ACC_W | Accumulators; cell (r,c) is at bits [(r*COLS+c)*ACC_W +: ACC_W] |

## Verification
An operand that is presented on the left or top edge changes the accumulator of the edge cell at the next rising edge. That operand affects the cell r rows and c columns further in only after r+c more enabled edges. Clear and hold show their effect at the first edge after they are asserted. The bench changes inputs on the falling edge and advances one full cycle per step. For each scenario it counts the edges to the cell under test, and it samples the accumulators on the falling edge after the last edge that matters. The expected values come from a bit-exact model of truncation, shift and OR-low adder that is kept inside the bench.

// File: rtl/amac_pkg.sv
// Package amac_pkg
// Holds the shared width helpers of the approximate MAC grid.
// Assumes that all operands are unsigned.
package amac_pkg;

    // Returns the slice width that is kept from an operand of width w.
    function automatic int keep_bits(input int w, input int m);
        return (m < w) ? m : w;
    endfunction

    // Returns the number of low bits that are dropped from an operand of width w.
    function automatic int drop_bits(input int w, input int m);
        return (m < w) ? (w - m) : 0;
    endfunction

endpackage

// File: rtl/amac_trunc_mul.sv
// Module amac_trunc_mul
// Cuts each operand down to its upper MUL_W bits, multiplies the two slices,
// and shifts the product left by the total number of dropped bits, which
// restores the product to full DW+WW scale. The module is purely combinational.
// Assumes unsigned operands.
module amac_trunc_mul
    import amac_pkg::*;
#(
    parameter int DW    = 8,
    parameter int WW    = 8,
    parameter int MUL_W = 6
) (
    input  logic [DW-1:0]    a_val,
    input  logic [WW-1:0]    b_val,
    output logic [DW+WW-1:0] scaled
);
    localparam int AK   = keep_bits(DW, MUL_W);
    localparam int BK   = keep_bits(WW, MUL_W);
    localparam int DROP = drop_bits(DW, MUL_W) + drop_bits(WW, MUL_W);
    localparam int PW   = AK + BK;
    localparam int FW   = DW + WW;

    logic [AK-1:0] a_top;
    logic [BK-1:0] b_top;
    logic [PW-1:0] narrow;

    // Select the high-order slices.
    always_comb begin
        a_top = a_val[DW-1 -: AK];
        b_top = b_val[WW-1 -: BK];
    end

    // Form the narrow product.
    always_comb begin
        narrow = {{BK{1'b0}}, a_top} * {{AK{1'b0}}, b_top};
    end

    // Restore the scale with a left shift.
    always_comb begin
        scaled = FW'(narrow) << DROP;
    end
endmodule

// File: rtl/amac_or_adder.sv
// Module amac_or_adder
// An approximate adder. The low OR_BITS bits are formed as a bitwise OR with
// no carry out of them. The upper bits get an exact add whose carry-in is the
// AND of both operands at bit OR_BITS-1. With OR_BITS = 0 the adder is exact.
// The result wraps at W bits. Assumes that W - OR_BITS >= 2.
module amac_or_adder #(
    parameter int W       = 20,
    parameter int OR_BITS = 6
) (
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    output logic [W-1:0] sum
);
    localparam int HW = W - OR_BITS;

    generate
        if (OR_BITS == 0) begin : g_exact
            // Plain exact addition.
            always_comb begin
                sum = x_in + y_in;
            end
        end else begin : g_approx
            logic [OR_BITS-1:0] low_part;
            logic [HW-1:0]      high_part;
            logic               guess_cy;

            // Carry-free lower section.
            always_comb begin
                low_part = x_in[OR_BITS-1:0] | y_in[OR_BITS-1:0];
                guess_cy = x_in[OR_BITS-1] & y_in[OR_BITS-1];
            end

            // Exact upper section with the predicted carry.
            always_comb begin
                high_part = x_in[W-1:OR_BITS] + y_in[W-1:OR_BITS] + HW'(guess_cy);
                sum       = {high_part, low_part};
            end
        end
    endgenerate
endmodule

// File: rtl/amac_cell.sv
// Module amac_cell
// One grid cell. It multiplies the incoming activation and weight with the
// truncating multiplier and adds the scaled product to its accumulator with the
// OR-low adder. It registers both operands for its right and lower neighbours.
// Operand registers advance only while en is high. Clear zeroes only the
// accumulator and takes priority over en.
module amac_cell #(
    parameter int DW      = 8,
    parameter int WW      = 8,
    parameter int MUL_W   = 6,
    parameter int OR_BITS = 6,
    parameter int ACC_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [DW-1:0]    a_in,
    input  logic [WW-1:0]    b_in,
    output logic [DW-1:0]    a_fwd,
    output logic [WW-1:0]    b_fwd,
    output logic [ACC_W-1:0] acc
);
    localparam int FW = DW + WW;

    logic [FW-1:0]    prod;
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_next;

    amac_trunc_mul #(
        .DW    (DW),
        .WW    (WW),
        .MUL_W (MUL_W)
    ) u_mul (
        .a_val  (a_in),
        .b_val  (b_in),
        .scaled (prod)
    );

    // Widen the product to the accumulator width.
    always_comb begin
        prod_ext = ACC_W'(prod);
    end

    amac_or_adder #(
        .W       (ACC_W),
        .OR_BITS (OR_BITS)
    ) u_add (
        .x_in (acc),
        .y_in (prod_ext),
        .sum  (acc_next)
    );

    // Accumulator with reset, clear and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc_next;
        end
    end

    // Operand forwarding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_fwd <= '0;
            b_fwd <= '0;
        end else if (en) begin
            a_fwd <= a_in;
            b_fwd <= b_in;
        end
    end
endmodule

// File: rtl/amac_grid.sv
// Module amac_grid
// A ROWS x COLS systolic grid of amac_cell. Activations enter at column 0 and
// move right. Weights enter at row 0 and move down. The caller skews row r by
// r cycles and column c by c cycles. All accumulators are visible on acc_out.
// Assumes DW in {8,16,32}, WW in {3..8,16,32}, MUL_W in 2..12, and
// ACC_W >= DW+WW.
module amac_grid #(
    parameter int ROWS    = 3,
    parameter int COLS    = 3,
    parameter int DW      = 8,
    parameter int WW      = 8,
    parameter int MUL_W   = 6,
    parameter int OR_BITS = 6,
    parameter int ACC_W   = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        en,
    input  logic [ROWS*DW-1:0]          feat_in,
    input  logic [COLS*WW-1:0]          wgt_in,
    output logic [ROWS*COLS*ACC_W-1:0]  acc_out
);
    localparam int CELLS = ROWS * COLS;

    logic [DW-1:0]    h_bus [ROWS][COLS+1];
    logic [WW-1:0]    v_bus [ROWS+1][COLS];
    logic [ACC_W-1:0] acc_q [CELLS];

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_left
            // Left edge feed of row r.
            always_comb begin
                h_bus[r][0] = feat_in[r*DW +: DW];
            end
        end
        for (genvar c = 0; c < COLS; c++) begin : g_top
            // Top edge feed of column c.
            always_comb begin
                v_bus[0][c] = wgt_in[c*WW +: WW];
            end
        end
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            for (genvar c = 0; c < COLS; c++) begin : g_col
                amac_cell #(
                    .DW      (DW),
                    .WW      (WW),
                    .MUL_W   (MUL_W),
                    .OR_BITS (OR_BITS),
                    .ACC_W   (ACC_W)
                ) u_cell (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .clr   (clr),
                    .en    (en),
                    .a_in  (h_bus[r][c]),
                    .b_in  (v_bus[r][c]),
                    .a_fwd (h_bus[r][c+1]),
                    .b_fwd (v_bus[r+1][c]),
                    .acc   (acc_q[r*COLS+c])
                );
                // Pack the accumulator of cell (r,c) onto the output.
                always_comb begin
                    acc_out[(r*COLS+c)*ACC_W +: ACC_W] = acc_q[r*COLS+c];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/amac_grid_chk.sv
// Module amac_grid_chk
// Assertion checker for amac_grid. It watches only the ports and is attached
// to every instance by the bind statement below.
module amac_grid_chk #(
    parameter int ROWS  = 3,
    parameter int COLS  = 3,
    parameter int DW    = 8,
    parameter int WW    = 8,
    parameter int ACC_W = 20
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       clr,
    input logic                       en,
    input logic [ROWS*DW-1:0]         feat_in,
    input logic [COLS*WW-1:0]         wgt_in,
    input logic [ROWS*COLS*ACC_W-1:0] acc_out
);
    logic past_ok;

    // Marks the cycles that have a valid previous sample after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_out == '0));

    assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !en && !clr) |=> $stable(acc_out));

    assert_zero_feat_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && en && !clr && feat_in[DW-1:0] == '0)
            |=> (acc_out[ACC_W-1:0] == $past(acc_out[ACC_W-1:0])));

    assert_zero_wgt_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && en && !clr && wgt_in[WW-1:0] == '0)
            |=> (acc_out[ACC_W-1:0] == $past(acc_out[ACC_W-1:0])));

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0));
endmodule

bind amac_grid amac_grid_chk #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .DW    (DW),
    .WW    (WW),
    .ACC_W (ACC_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .en      (en),
    .feat_in (feat_in),
    .wgt_in  (wgt_in),
    .acc_out (acc_out)
);

// File: tb/sim_amac_grid.sv
`timescale 1ns/1ps
module sim_amac_grid;
    localparam int R  = 3;
    localparam int C  = 3;
    localparam int DW = 8;
    localparam int WW = 8;
    localparam int MW = 6;
    localparam int K  = 6;
    localparam int AW = 20;
    localparam int KD = 4;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 clr = 1'b0;
    logic                 en = 1'b0;
    logic [R*DW-1:0]      feat_in = '0;
    logic [C*WW-1:0]      wgt_in = '0;
    logic [R*C*AW-1:0]    acc_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    amac_grid #(.ROWS(R), .COLS(C), .DW(DW), .WW(WW), .MUL_W(MW),
                .OR_BITS(K), .ACC_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en),
        .feat_in(feat_in), .wgt_in(wgt_in), .acc_out(acc_out));

    // Model of the scaled product: upper slices, then shift by the dropped bits.
    function automatic longint unsigned m_mul(longint unsigned f, longint unsigned w);
        longint unsigned ft = f >> (DW - MW);
        longint unsigned wt = w >> (WW - MW);
        return (ft * wt) << ((DW - MW) + (WW - MW));
    endfunction

    // Model of the OR-low adder with a predicted carry-in.
    function automatic longint unsigned m_add(longint unsigned a, longint unsigned b);
        longint unsigned lo = (a | b) & ((64'd1 << K) - 1);
        longint unsigned hi = (a >> K) + (b >> K) + (((a >> (K-1)) & (b >> (K-1))) & 1);
        return ((hi << K) | lo) & ((64'd1 << AW) - 1);
    endfunction

    function automatic longint unsigned acc_of(int r, int c);
        return longint'(acc_out[(r*C+c)*AW +: AW]);
    endfunction

    task automatic chk(string req, longint unsigned act, longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic zero_inputs();
        feat_in = '0;
        wgt_in  = '0;
    endtask

    task automatic do_clear();
        zero_inputs();
        en  = 1'b1;
        clr = 1'b1;
        step();
        clr = 1'b0;
        step();
    endtask

    // R1: everything is zero after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        @(negedge clk);
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++)
                chk("R1 reset acc", acc_of(r, c), 0);
    endtask

    // R5 and R7: scaled product, then forwarding right and down.
    task automatic t_forward();
        en = 1'b1;
        feat_in[0 +: DW] = 8'hF0;
        wgt_in[0 +: WW]  = 8'hF0;
        step();
        chk("R5 scaled product 0xF0*0xF0", acc_of(0, 0), 64'hE100);
        chk("R7 neighbour untouched", acc_of(0, 1), 0);
        zero_inputs();
        wgt_in[1*WW +: WW]  = 8'h30;
        feat_in[1*DW +: DW] = 8'h20;
        step();
        chk("R7 activation moved right", acc_of(0, 1), m_mul(8'hF0, 8'h30));
        chk("R7 weight moved down", acc_of(1, 0), m_mul(8'h20, 8'hF0));
        chk("R9 zero input keeps acc", acc_of(0, 0), 64'hE100);
        zero_inputs();
        step();
    endtask

    // R2: clear wins over enable and nonzero data.
    task automatic t_clear();
        en = 1'b1;
        clr = 1'b1;
        feat_in[0 +: DW] = 8'hFF;
        wgt_in[0 +: WW]  = 8'hFF;
        step();
        clr = 1'b0;
        zero_inputs();
        for (int r = 0; r < R; r++)
            for (int c = 0; c < C; c++)
                chk("R2 clear acc", acc_of(r, c), 0);
        step();
    endtask

    // R4: low bits are dropped from the operands.
    task automatic t_trunc();
        do_clear();
        feat_in[0 +: DW] = 8'h03;
        wgt_in[0 +: WW]  = 8'hFF;
        step();
        chk("R4 low bits ignored", acc_of(0, 0), 0);
        feat_in[0 +: DW] = 8'h07;
        wgt_in[0 +: WW]  = 8'h07;
        step();
        chk("R4 0x07 acts as 0x04", acc_of(0, 0), 64'h10);
        zero_inputs();
        step();
    endtask

    // R6: OR-low adder with the predicted carry.
    task automatic t_adder();
        do_clear();
        feat_in[0 +: DW] = 8'hFC;
        wgt_in[0 +: WW]  = 8'h04;
        step();
        chk("R6 first add", acc_of(0, 0), 64'h3F0);
        step();
        chk("R6 second add approx", acc_of(0, 0), 64'h7F0);
        feat_in[0 +: DW] = 8'h14;
        step();
        chk("R6 third add model", acc_of(0, 0), m_add(64'h7F0, m_mul(8'h14, 8'h04)));
        zero_inputs();
        step();
    endtask

    // R3: hold while en is low, including the forwarding registers.
    task automatic t_hold();
        longint unsigned keep;
        keep = acc_of(0, 0);
        en = 1'b0;
        feat_in[0 +: DW] = 8'h80;
        wgt_in[0 +: WW]  = 8'h80;
        step();
        step();
        chk("R3 acc held while idle", acc_of(0, 0), keep);
        en = 1'b1;
        zero_inputs();
        wgt_in[1*WW +: WW] = 8'h40;
        step();
        chk("R3 idle activation not forwarded", acc_of(0, 1), 0);
        zero_inputs();
        step();
    endtask

    // R8: skewed matrix product against the model.
    task automatic t_matrix();
        longint unsigned a [R][KD];
        longint unsigned b [KD][C];
        longint unsigned e;
        for (int i = 0; i < R; i++)
            for (int k = 0; k < KD; k++)
                a[i][k] = (37*i + 53*k + 11) & 255;
        for (int k = 0; k < KD; k++)
            for (int j = 0; j < C; j++)
                b[k][j] = (71*k + 29*j + 190) & 255;
        do_clear();
        for (int t = 0; t < KD + R + C; t++) begin
            for (int i = 0; i < R; i++)
                feat_in[i*DW +: DW] = (t-i >= 0 && t-i < KD) ? DW'(a[i][t-i]) : '0;
            for (int j = 0; j < C; j++)
                wgt_in[j*WW +: WW] = (t-j >= 0 && t-j < KD) ? WW'(b[t-j][j]) : '0;
            step();
        end
        zero_inputs();
        for (int i = 0; i < R; i++)
            for (int j = 0; j < C; j++) begin
                e = 0;
                for (int k = 0; k < KD; k++)
                    e = m_add(e, m_mul(a[i][k], b[k][j]));
                chk("R8 matrix cell", acc_of(i, j), e);
            end
    endtask

    initial begin
        t_reset();
        t_forward();
        t_clear();
        t_trunc();
        t_adder();
        t_hold();
        t_matrix();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule